// File: doc/BRIEF.md
# I2C DMA Byte Transfer Engine

This block moves the data bytes of an I2C packet between a byte-wide memory port and the bus sequencer. Software loads a buffer address and an encoded length, and the sequencer then starts a transfer in one direction.

For a transmit transfer, the engine reads one byte from memory and offers it to the sequencer. It then waits for the sequencer to report whether the target acknowledged the byte. For a receive transfer, the engine takes each byte from the sequencer and writes it to memory.

The engine keeps one counter of transmitted bytes and one of received bytes. Both appear in a single status word.

Every data interface is valid/ready:
- A transfer happens on a cycle where valid and ready are both high.
- Once the engine raises a valid (`mem_req_valid`, `tx_valid`), it holds the valid and its payload stable until ready is seen.
- The engine raises `mem_rsp_ready` only while it is waiting for a response.
- The engine raises `rx_ready` only while it wants a received byte.
- A producer may hold its valid for as long as it likes, and that stalls the engine without loss.
- The transmit result (`tx_res_valid`) is a one-cycle pulse with no ready. The engine only waits for it after a transmit handshake.

Top module: `i2c_dma_engine`

## Requirements
- R1: A write to the length register (`reg_sel` = 0) with bit 15 set loads bits 11:0 plus one. Otherwise, if bit 31 is set, it loads bits 27:16 plus one. With neither bit set, the length is left unchanged. Bit 15 takes priority when both are set.
- R2: The length never exceeds 4096. A read of the length register returns the remaining length masked to its low 12 bits, so 4096 reads as 0.
- R3: A write with `reg_sel` 1 or 2 loads one shared 31-bit address register and drops bit 31. A read of either select returns that same register.
- R4: Each byte moved adds one to the address and subtracts one from the remaining length. A transfer ends once the remaining length reaches zero.
- R5: A transmit transfer reads bytes from memory in ascending address order and presents them on `tx_data`. Each byte accepted by the sequencer adds one to the transmit count, which is reported in status bits 15:0 (`reg_sel` = 3).
- R6: A receive transfer writes each byte taken from `rx_data` to ascending memory addresses. Each successful write adds one to the receive count, which is reported in status bits 31:16.
- R7: Any write to the status word clears both counters, and so does a `pkt_clr` pulse. The clear takes priority over a concurrent increment.
- R8: A NAK result on a transmitted byte ends the transfer. `xfer_nak` is raised together with `xfer_done`, and the NAKed byte is still counted.
- R9: A memory response with `mem_rsp_err` set ends the transfer. `xfer_abort` is raised together with `xfer_done`, and that byte does not advance the address, the length or any counter.
- R10: While `xfer_busy` is high, writes to the length and address registers are ignored.
- R11: Starting a transfer with a remaining length of zero gives `xfer_done` one cycle later, with no memory or sequencer traffic.
- R12: `mem_req_valid` and `tx_valid` stay high with a stable payload until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 length, 1/2 address, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| pkt_clr | input | 1 | Start of a packet command; clears both counters |
| xfer_go | input | 1 | Start pulse, honoured only while idle |
| xfer_rx | input | 1 | Direction for `xfer_go`: 1 receive, 0 transmit |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse when a transfer ends |
| xfer_nak | output | 1 | With `xfer_done`: transmit ended on a NAK |
| xfer_abort | output | 1 | With `xfer_done`: transfer ended on a memory error |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 31 | Byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Engine waits for a response |
| mem_rsp_err | input | 1 | Response reports an error |
| mem_rsp_rdata | input | 8 | Read data |
| tx_valid | output | 1 | Byte offered to the sequencer |
| tx_ready | input | 1 | Sequencer accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_res_valid | input | 1 | Result pulse for the last accepted byte |
| tx_res_nak | input | 1 | Result was a NAK |
| rx_valid | input | 1 | Sequencer offers a received byte |
| rx_ready | output | 1 | Engine takes a received byte |
| rx_data | input | 8 | Received byte |

## Verification
The embedded assertions check the following on every cycle:
- The remaining length stays within 4096.
- No byte steps the address or length once the length is already zero.
- Transmit and receive steps never coincide.
- A status write leaves both counters at zero.
- Request and transmit valids hold their payload under back-pressure.

Only the directed scenarios can show the rest:
- The length field encoding, the address masking and the shared address register.
- Byte ordering against memory contents.
- The packed counter values.
- Early termination on a NAK or a memory error, with the exact residual length and address.
- Register writes ignored during a transfer.

// File: rtl/i2c_dma_pkg.sv
package i2c_dma_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_LEN   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_TXADR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RXADR = 2'd2;
  localparam logic [SEL_W-1:0] SEL_STAT  = 2'd3;
  localparam int LO_EN_BIT = 15;
  localparam int HI_EN_BIT = 31;
  localparam int HI_FIELD_LSB = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX_REQ,
    ST_TX_RSP,
    ST_TX_SEND,
    ST_TX_RES,
    ST_RX_WAIT,
    ST_RX_REQ,
    ST_RX_RSP,
    ST_FIN
  } dma_state_e;
endpackage

// File: rtl/i2c_dma_regs.sv
module i2c_dma_regs
  import i2c_dma_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              pkt_clr,
  input  logic              step_tx,
  input  logic              step_rx,
  output logic [ADDR_W-1:0] addr,
  output logic              len_zero,
  output logic              len_one
);
  localparam int LEN_BITS = LEN_W + 1;
  localparam logic [LEN_BITS-1:0] MAX_LEN = LEN_BITS'(1) << LEN_W;

  logic [LEN_BITS-1:0] len_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [CNT_W-1:0]    tx_cnt, rx_cnt;
  logic                step;
  logic                cnt_clr;
  logic                len_wr, addr_wr;

  assign step    = step_tx | step_rx;
  assign cnt_clr = pkt_clr | (wr_en && sel == SEL_STAT);
  assign len_wr  = wr_en && !busy && sel == SEL_LEN;
  assign addr_wr = wr_en && !busy && (sel == SEL_TXADR || sel == SEL_RXADR);

  // length register: two encoded fields, low field has priority
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_wr && wdata[LO_EN_BIT]) begin
      len_q <= {1'b0, wdata[LEN_W-1:0]} + LEN_BITS'(1);
    end else if (len_wr && wdata[HI_EN_BIT]) begin
      len_q <= {1'b0, wdata[HI_FIELD_LSB+LEN_W-1:HI_FIELD_LSB]} + LEN_BITS'(1);
    end else if (step) begin
      len_q <= len_q - LEN_BITS'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_wr) begin
      addr_q <= wdata[ADDR_W-1:0];
    end else if (step) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else if (cnt_clr) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else begin
      if (step_tx) tx_cnt <= tx_cnt + CNT_W'(1);
      if (step_rx) rx_cnt <= rx_cnt + CNT_W'(1);
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_LEN:   rdata[LEN_W-1:0] = len_q[LEN_W-1:0];
      SEL_TXADR,
      SEL_RXADR: rdata[ADDR_W-1:0] = addr_q;
      default:   rdata = {16'(rx_cnt), 16'(tx_cnt)};
    endcase
  end

  assign addr     = addr_q;
  assign len_zero = (len_q == '0);
  assign len_one  = (len_q == LEN_BITS'(1));

  // R2
  len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= MAX_LEN);
  // R4
  step_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> len_q != '0);
  // R4
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_tx, step_rx}));
  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_STAT) |=> (tx_cnt == '0 && rx_cnt == '0));
endmodule

// File: rtl/i2c_dma_ctrl.sv
module i2c_dma_ctrl
  import i2c_dma_pkg::*;
#(
  parameter int ADDR_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_rx,
  output logic              busy,
  output logic              done,
  output logic              nak,
  output logic              abort,
  input  logic              len_zero,
  input  logic              len_one,
  input  logic [ADDR_W-1:0] addr,
  output logic              step_tx,
  output logic              step_rx,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic              mem_rsp_err,
  input  logic [7:0]        mem_rsp_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              tx_res_valid,
  input  logic              tx_res_nak,
  output logic              rx_valid_ack,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data
);
  dma_state_e state_q, state_d;
  logic [7:0] byte_q;
  logic       nak_q, abort_q;
  logic       rsp_take;

  assign rsp_take = mem_rsp_valid && mem_rsp_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (go) state_d = len_zero ? ST_FIN : (go_rx ? ST_RX_WAIT : ST_TX_REQ);
      ST_TX_REQ:  if (mem_req_ready) state_d = ST_TX_RSP;
      ST_TX_RSP:  if (mem_rsp_valid) state_d = mem_rsp_err ? ST_FIN : ST_TX_SEND;
      ST_TX_SEND: if (tx_ready) state_d = ST_TX_RES;
      ST_TX_RES:  if (tx_res_valid) state_d = (tx_res_nak || len_zero) ? ST_FIN : ST_TX_REQ;
      ST_RX_WAIT: if (rx_valid) state_d = ST_RX_REQ;
      ST_RX_REQ:  if (mem_req_ready) state_d = ST_RX_RSP;
      ST_RX_RSP:  if (mem_rsp_valid) state_d = (mem_rsp_err || len_one) ? ST_FIN : ST_RX_WAIT;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
      nak_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go) begin
        nak_q   <= 1'b0;
        abort_q <= 1'b0;
      end
      if (state_q == ST_TX_RSP && rsp_take) begin
        if (mem_rsp_err) abort_q <= 1'b1;
        else             byte_q  <= mem_rsp_rdata;
      end
      if (state_q == ST_RX_RSP && rsp_take && mem_rsp_err) abort_q <= 1'b1;
      if (state_q == ST_RX_WAIT && rx_valid) byte_q <= rx_data;
      if (state_q == ST_TX_RES && tx_res_valid && tx_res_nak) nak_q <= 1'b1;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = (state_q == ST_FIN);
  assign nak           = done && nak_q;
  assign abort         = done && abort_q;
  assign mem_req_valid = (state_q == ST_TX_REQ) || (state_q == ST_RX_REQ);
  assign mem_req_we    = (state_q == ST_RX_REQ);
  assign mem_req_addr  = addr;
  assign mem_req_wdata = byte_q;
  assign mem_rsp_ready = (state_q == ST_TX_RSP) || (state_q == ST_RX_RSP);
  assign tx_valid      = (state_q == ST_TX_SEND);
  assign tx_data       = byte_q;
  assign rx_valid_ack  = (state_q == ST_RX_WAIT);
  assign step_tx       = tx_valid && tx_ready;
  assign step_rx       = (state_q == ST_RX_RSP) && rsp_take && !mem_rsp_err;

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R9
  abort_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_ready && mem_rsp_valid && mem_rsp_err) |=> done);
endmodule

// File: rtl/i2c_dma_engine.sv
module i2c_dma_engine
  import i2c_dma_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pkt_clr,
  input  logic              xfer_go,
  input  logic              xfer_rx,
  output logic              xfer_busy,
  output logic              xfer_done,
  output logic              xfer_nak,
  output logic              xfer_abort,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic              mem_rsp_err,
  input  logic [7:0]        mem_rsp_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              tx_res_valid,
  input  logic              tx_res_nak,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data
);
  logic              step_tx, step_rx;
  logic              len_zero, len_one;
  logic [ADDR_W-1:0] cur_addr;

  i2c_dma_regs #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .busy     (xfer_busy),
    .pkt_clr  (pkt_clr),
    .step_tx  (step_tx),
    .step_rx  (step_rx),
    .addr     (cur_addr),
    .len_zero (len_zero),
    .len_one  (len_one)
  );

  i2c_dma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (xfer_go),
    .go_rx         (xfer_rx),
    .busy          (xfer_busy),
    .done          (xfer_done),
    .nak           (xfer_nak),
    .abort         (xfer_abort),
    .len_zero      (len_zero),
    .len_one       (len_one),
    .addr          (cur_addr),
    .step_tx       (step_tx),
    .step_rx       (step_rx),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_err   (mem_rsp_err),
    .mem_rsp_rdata (mem_rsp_rdata),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .tx_res_valid  (tx_res_valid),
    .tx_res_nak    (tx_res_nak),
    .rx_valid_ack  (rx_ready),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data)
  );
endmodule

// File: tb/sim_i2c_dma_engine.sv
module sim_i2c_dma_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_wr = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        pkt_clr = 0, xfer_go = 0, xfer_rx = 0;
  logic        xfer_busy, xfer_done, xfer_nak, xfer_abort;
  logic        mem_req_valid, mem_req_we, mem_rsp_ready;
  logic        mem_req_ready;
  logic [30:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [7:0]  mem_rsp_rdata;
  logic        tx_valid, tx_res_valid, tx_res_nak;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;

  i2c_dma_engine u0 (.*);

  int tests = 0, fails = 0, cyc = 0;

  // bench controls
  logic        stall = 0, err_en = 0;
  logic [5:0]  err_addr = 0;
  int          nak_idx = -1;
  int          rx_lim = 0;

  // memory model
  logic [7:0] mem [64];
  logic       mready;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
      mready <= 1'b1; mem_rsp_valid <= 1'b0; mem_rsp_err <= 1'b0; mem_rsp_rdata <= 0;
    end else begin
      mready <= stall ? ~mready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_err   <= err_en && (mem_req_addr[5:0] == err_addr);
        mem_rsp_rdata <= mem[mem_req_addr[5:0]];
        if (mem_req_we && !(err_en && mem_req_addr[5:0] == err_addr))
          mem[mem_req_addr[5:0]] <= mem_req_wdata;
      end else if (mem_rsp_valid && mem_rsp_ready) begin
        mem_rsp_valid <= 1'b0;
      end
    end
  end
  assign mem_req_ready = mready;

  // sequencer model
  int         tx_n, rx_i;
  logic [7:0] txlog [64];
  always @(posedge clk) begin
    if (!rst_n) begin
      tx_n <= 0; rx_i <= 0; tx_res_valid <= 0; tx_res_nak <= 0;
    end else begin
      tx_res_valid <= 1'b0;
      if (tx_valid && tx_ready) begin
        txlog[tx_n[5:0]] <= tx_data;
        tx_res_valid <= 1'b1;
        tx_res_nak   <= (tx_n == nak_idx);
        tx_n <= tx_n + 1;
      end
      if (rx_valid && rx_ready) rx_i <= rx_i + 1;
    end
  end
  assign rx_valid = (rx_i < rx_lim);
  assign rx_data  = 8'hC0 ^ 8'(rx_i);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1; tests = tests + 1;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic start(input logic rx);
    @(negedge clk); xfer_go = 1; xfer_rx = rx;
    @(negedge clk); xfer_go = 0;
  endtask

  task automatic wait_done(output logic nk, output logic ab);
    nk = 0; ab = 0;
    for (int i = 0; i < 2000; i++) begin
      if (xfer_done) begin nk = xfer_nak; ab = xfer_abort; return; end
      @(negedge clk);
    end
    chk("R4 done timeout", 0, 1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3, v); chk("R7 reset status", v, 0);
    rd(0, v); chk("R2 reset length", v, 0);
    chk("R11 reset idle", {31'b0, xfer_busy}, 0);
  endtask

  task automatic t_zero_len;
    logic nk, ab; int t0;
    t0 = tx_n;
    start(0);
    chk("R11 done after zero-length start", {31'b0, xfer_done}, 1);
    wait_done(nk, ab);
    chk("R11 no bytes sent", tx_n, t0);
  endtask

  task automatic t_len_enc;
    logic [31:0] v;
    wr(0, 32'h0000_8004); rd(0, v); chk("R1 low field", v, 5);
    wr(0, 32'h8009_0000); rd(0, v); chk("R1 high field", v, 10);
    wr(0, 32'h8002_8006); rd(0, v); chk("R1 low field priority", v, 7);
    wr(0, 32'h7FFF_7FFF); rd(0, v); chk("R1 no enable unchanged", v, 7);
    wr(0, 32'h0000_8FFF); rd(0, v); chk("R2 max length reads 0", v, 0);
  endtask

  task automatic t_addr;
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R3 bit31 masked", v, 32'h7FFF_FFFF);
    wr(2, 32'h0000_0123); rd(1, v); chk("R3 shared register", v, 32'h123);
  endtask

  task automatic t_tx;
    logic nk, ab; logic [31:0] v; int t0;
    wr(3, 0);
    stall = 1; t0 = tx_n;
    wr(1, 8); wr(0, 32'h0000_8003);
    start(0); wait_done(nk, ab); stall = 0;
    chk("R5 four bytes sent", tx_n - t0, 4);
    for (int k = 0; k < 4; k++) chk("R5 tx byte order", txlog[6'(t0 + k)], 8'((8 + k) * 7 + 3));
    rd(1, v); chk("R4 address advanced", v, 12);
    rd(0, v); chk("R4 length drained", v, 0);
    rd(3, v); chk("R5 tx count low half", v, 32'h0000_0004);
  endtask

  task automatic t_rx;
    logic nk, ab; logic [31:0] v; int r0;
    r0 = rx_i; rx_lim = r0 + 3;
    wr(1, 20); wr(0, 32'h8002_0000);
    start(1); wait_done(nk, ab);
    for (int k = 0; k < 3; k++) chk("R6 rx byte stored", mem[20 + k], 8'hC0 ^ 8'(r0 + k));
    rd(3, v); chk("R6 rx count high half, tx kept", v, 32'h0003_0004);
    wr(3, 32'h1234_5678); rd(3, v); chk("R7 status write clears", v, 0);
  endtask

  task automatic t_pkt_clr;
    logic nk, ab; logic [31:0] v;
    wr(1, 0); wr(0, 32'h0000_8001);
    start(0); wait_done(nk, ab);
    rd(3, v); chk("R5 count before clear", v, 2);
    @(negedge clk); pkt_clr = 1; @(negedge clk); pkt_clr = 0;
    rd(3, v); chk("R7 pkt_clr clears", v, 0);
  endtask

  task automatic t_nak;
    logic nk, ab; logic [31:0] v;
    nak_idx = tx_n + 1;
    wr(1, 0); wr(0, 32'h0000_8004);
    start(0); wait_done(nk, ab);
    chk("R8 nak flag", {31'b0, nk}, 1);
    rd(3, v); chk("R8 nacked byte counted", v, 2);
    rd(0, v); chk("R8 remaining length", v, 3);
    rd(1, v); chk("R8 address after nak", v, 2);
    nak_idx = -1; wr(3, 0);
  endtask

  task automatic t_rx_err;
    logic nk, ab; logic [31:0] v;
    err_en = 1; err_addr = 51; rx_lim = rx_i + 3;
    wr(1, 50); wr(0, 32'h0000_8002);
    start(1); wait_done(nk, ab);
    chk("R9 abort flag", {31'b0, ab}, 1);
    rd(3, v); chk("R9 failed byte not counted", v, 32'h0001_0000);
    rd(0, v); chk("R9 length after abort", v, 2);
    rd(1, v); chk("R9 address after abort", v, 51);
    err_en = 0; rx_lim = rx_i; wr(3, 0);
  endtask

  task automatic t_tx_err;
    logic nk, ab; logic [31:0] v; int t0;
    t0 = tx_n; err_en = 1; err_addr = 30;
    wr(1, 30); wr(0, 32'h0000_8001);
    start(0); wait_done(nk, ab);
    chk("R9 tx abort flag", {31'b0, ab}, 1);
    chk("R9 nothing sent", tx_n, t0);
    rd(3, v); chk("R9 tx count zero", v, 0);
    err_en = 0;
  endtask

  task automatic t_busy_ignore;
    logic nk, ab; logic [31:0] v; int r0;
    r0 = rx_i; rx_lim = r0;
    wr(1, 40); wr(0, 32'h0000_8001);
    start(1);
    chk("R10 busy while waiting", {31'b0, xfer_busy}, 1);
    wr(0, 32'h0000_8007); wr(1, 5);
    rd(0, v); chk("R10 length write ignored", v, 2);
    rd(1, v); chk("R10 address write ignored", v, 40);
    rx_lim = r0 + 2;
    wait_done(nk, ab);
    chk("R6 byte at 41", mem[41], 8'hC0 ^ 8'(r0 + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_len_enc();
    t_addr();
    t_tx();
    t_rx();
    t_pkt_clr();
    t_nak();
    t_rx_err();
    t_tx_err();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule